// File: doc/BRIEF.md
# Manual-Mode Master Clock Switch Controller

This block decides which of three clock sources drives the master clock and changes that choice only through a two-step software handshake. Software writes the code of the wanted source into the target register. The block marks itself busy and requests power-up of that source. When the source signals that it is ready, the block raises a ready flag, and it also asserts an interrupt if interrupts are enabled. The master source stays where it is until software writes the execute bit. At that point the status register takes the target code, the glitch-free mux select moves to the new source, and the busy flag drops.

The three sources are an internal RC oscillator divided by 8, an external crystal and a low-speed internal oscillator. Each one has an enable output and a ready input, and the block assumes both are synchronous to its clock. Software reaches the block through a small write/read register bus. Read data is registered, so it appears one cycle after the address is presented. Clearing the busy flag in software abandons a pending switch, for example when the target source has failed.

Top module: `mcs_switch_ctrl`

## Requirements
- R1: After reset, the target register (address 0) and the status register (address 2) both read E1h. The select output is 001, the enable output is 001, the control register (address 1) reads 00h and the interrupt is low. Select and enable bits are indexed 0 = internal RC/8 (code E1h), 1 = crystal (code B4h), 2 = low-speed internal (code D2h).
- R2: A write of a valid source code to address 0 while idle stores the code and sets the busy bit (control bit 0). From then until the switch ends, the enable output holds the target source's bit together with the current master's bit.
- R3: While busy, the ready flag (control bit 1) is set when the target source's ready input is high. The interrupt output rises one cycle after the flag is set, and only if the interrupt-enable bit (control bit 2, read/write) is 1.
- R4: The status register and the select output do not change until execute (control bit 3, write-only, reads 0) is written as 1 after the ready flag has been raised. An execute write made earlier is ignored.
- R5: On execute, the status register takes the target code and the busy bit and the ready flag clear. The select output becomes the one-hot of the new master, and the enable output drops every source except the new master.
- R6: Writing 0 to the busy bit aborts a pending switch: the master is unchanged and the target's enable is dropped. If the same control write also carries execute=1, the abort wins.
- R7: A write to address 0 of any code other than E1h, B4h or D2h is ignored.
- R8: Writing 0 to the ready flag clears it without cancelling the switch. The flag is not raised again for the same switch, and a later execute still completes it. Writing 1 to the busy or flag bit has no effect.
- R9: A write to address 0 while busy is ignored, so the target register keeps its code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 target, 1 control, 2 status) |
| wdata | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data for the address of the previous cycle |
| src_rdy_i | input | 3 | Per-source ready indications |
| src_en_o | output | 3 | Per-source enable requests, registered |
| sel_o | output | 3 | One-hot select for the glitch-free clock mux, registered |
| irq_o | output | 1 | Switch-ready interrupt, registered |

## Verification
Two functions can land in the same cycle: an abort and an execute, when a single control write clears the busy bit and also sets the execute bit while the ready flag is up. The bench provokes this with exactly such a write after the crystal-to-low-speed target has reported ready. It judges the outcome by reading back that the status register still holds the old master, that busy is clear, and that the select and enable outputs show only the old source. A second pairing is also exercised: a clear of the ready flag while the ready input stays high. The bench confirms that the flag stays low and that execute still goes through.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int NSRC = 3;
  localparam int CW   = 8;
  localparam int AW   = 2;

  localparam logic [CW-1:0] SRC_CODES [NSRC] = '{8'hE1, 8'hB4, 8'hD2};
  localparam int RST_IDX = 0;

  localparam logic [AW-1:0] A_TGT  = 2'd0;
  localparam logic [AW-1:0] A_CTL  = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;

  localparam int CB_BUSY = 0;
  localparam int CB_FLAG = 1;
  localparam int CB_IE   = 2;
  localparam int CB_EXEC = 3;
endpackage

// File: rtl/mcs_codec.sv
module mcs_codec #(
  parameter int NSRC = mcs_pkg::NSRC,
  parameter int CW   = mcs_pkg::CW
) (
  input  logic [CW-1:0]   code,
  output logic            valid,
  output logic [NSRC-1:0] onehot
);
  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign onehot[g] = (code == mcs_pkg::SRC_CODES[g]);
  end
  assign valid = |onehot;
endmodule

// File: rtl/mcs_core.sv
module mcs_core #(
  parameter int NSRC = mcs_pkg::NSRC,
  parameter int CW   = mcs_pkg::CW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_tgt,
  input  logic            wr_ctl,
  input  logic [CW-1:0]   wdata,
  input  logic            code_ok,
  input  logic [NSRC-1:0] code_oh,
  input  logic [NSRC-1:0] src_rdy,
  output logic [CW-1:0]   tgt_code_q,
  output logic [NSRC-1:0] tgt_oh_q,
  output logic [CW-1:0]   mst_code_q,
  output logic [NSRC-1:0] mst_oh_q,
  output logic            busy_q,
  output logic            flag_q,
  output logic            seen_q,
  output logic            ie_q
);
  import mcs_pkg::*;

  localparam logic [CW-1:0]   RST_CODE = SRC_CODES[RST_IDX];
  localparam logic [NSRC-1:0] RST_OH   = NSRC'(1) << RST_IDX;

  logic hw_set, abort, go, accept;

  assign accept = wr_tgt && !busy_q && code_ok;
  assign hw_set = busy_q && !seen_q && |(src_rdy & tgt_oh_q);
  assign abort  = wr_ctl && busy_q && !wdata[CB_BUSY];
  assign go     = wr_ctl && busy_q && wdata[CB_BUSY] && wdata[CB_EXEC] && seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_code_q <= RST_CODE;
      tgt_oh_q   <= RST_OH;
      mst_code_q <= RST_CODE;
      mst_oh_q   <= RST_OH;
      busy_q     <= 1'b0;
      flag_q     <= 1'b0;
      seen_q     <= 1'b0;
      ie_q       <= 1'b0;
    end else begin
      if (accept) begin
        tgt_code_q <= wdata;
        tgt_oh_q   <= code_oh;
        busy_q     <= 1'b1;
        seen_q     <= 1'b0;
        flag_q     <= 1'b0;
      end
      if (wr_ctl) ie_q <= wdata[CB_IE];
      if (wr_ctl && !wdata[CB_FLAG]) flag_q <= 1'b0;
      if (hw_set) begin
        flag_q <= 1'b1;
        seen_q <= 1'b1;
      end
      if (abort) begin
        busy_q <= 1'b0;
        flag_q <= 1'b0;
      end else if (go) begin
        busy_q     <= 1'b0;
        flag_q     <= 1'b0;
        mst_code_q <= tgt_code_q;
        mst_oh_q   <= tgt_oh_q;
      end
    end
  end
endmodule

// File: rtl/mcs_outreg.sv
module mcs_outreg #(
  parameter int NSRC = mcs_pkg::NSRC,
  parameter int CW   = mcs_pkg::CW,
  parameter int AW   = mcs_pkg::AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   tgt_code,
  input  logic [NSRC-1:0] tgt_oh,
  input  logic [CW-1:0]   mst_code,
  input  logic [NSRC-1:0] mst_oh,
  input  logic            busy,
  input  logic            flag,
  input  logic            ie,
  output logic [CW-1:0]   rdata_o,
  output logic [NSRC-1:0] sel_o,
  output logic [NSRC-1:0] src_en_o,
  output logic            irq_o
);
  import mcs_pkg::*;

  localparam logic [NSRC-1:0] RST_OH = NSRC'(1) << RST_IDX;

  logic [CW-1:0] ctl_view, rd_mux;

  always_comb begin
    ctl_view = '0;
    ctl_view[CB_BUSY] = busy;
    ctl_view[CB_FLAG] = flag;
    ctl_view[CB_IE]   = ie;
  end

  always_comb begin
    case (addr)
      A_TGT:   rd_mux = tgt_code;
      A_CTL:   rd_mux = ctl_view;
      A_STAT:  rd_mux = mst_code;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      sel_o    <= RST_OH;
      src_en_o <= RST_OH;
      irq_o    <= 1'b0;
    end else begin
      rdata_o  <= rd_mux;
      sel_o    <= mst_oh;
      src_en_o <= mst_oh | (busy ? tgt_oh : '0);
      irq_o    <= flag && ie;
    end
  end
endmodule

// File: rtl/mcs_switch_ctrl.sv
module mcs_switch_ctrl #(
  parameter int NSRC = mcs_pkg::NSRC,
  parameter int CW   = mcs_pkg::CW,
  parameter int AW   = mcs_pkg::AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [CW-1:0]   wdata,
  output logic [CW-1:0]   rdata_o,
  input  logic [NSRC-1:0] src_rdy_i,
  output logic [NSRC-1:0] src_en_o,
  output logic [NSRC-1:0] sel_o,
  output logic            irq_o
);
  import mcs_pkg::*;

  logic            code_ok;
  logic [NSRC-1:0] code_oh;
  logic [CW-1:0]   tgt_code_q, mst_code_q;
  logic [NSRC-1:0] tgt_oh_q, mst_oh_q;
  logic            busy_q, flag_q, seen_q, ie_q;
  logic            wr_tgt, wr_ctl;

  assign wr_tgt = wr_en && (addr == A_TGT);
  assign wr_ctl = wr_en && (addr == A_CTL);

  mcs_codec #(.NSRC(NSRC), .CW(CW)) u_codec (
    .code(wdata), .valid(code_ok), .onehot(code_oh)
  );

  mcs_core #(.NSRC(NSRC), .CW(CW)) u_core (
    .clk(clk), .rst(rst), .wr_tgt(wr_tgt), .wr_ctl(wr_ctl), .wdata(wdata),
    .code_ok(code_ok), .code_oh(code_oh), .src_rdy(src_rdy_i),
    .tgt_code_q(tgt_code_q), .tgt_oh_q(tgt_oh_q),
    .mst_code_q(mst_code_q), .mst_oh_q(mst_oh_q),
    .busy_q(busy_q), .flag_q(flag_q), .seen_q(seen_q), .ie_q(ie_q)
  );

  mcs_outreg #(.NSRC(NSRC), .CW(CW), .AW(AW)) u_out (
    .clk(clk), .rst(rst), .addr(addr),
    .tgt_code(tgt_code_q), .tgt_oh(tgt_oh_q),
    .mst_code(mst_code_q), .mst_oh(mst_oh_q),
    .busy(busy_q), .flag(flag_q), .ie(ie_q),
    .rdata_o(rdata_o), .sel_o(sel_o), .src_en_o(src_en_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int NSRC = mcs_pkg::NSRC,
  parameter int CW   = mcs_pkg::CW
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] sel_o,
  input logic [NSRC-1:0] src_en_o,
  input logic            irq_o,
  input logic [CW-1:0]   tgt_code_q,
  input logic [NSRC-1:0] tgt_oh_q,
  input logic [CW-1:0]   mst_code_q,
  input logic            busy_q,
  input logic            seen_q,
  input logic            ie_q
);
  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(sel_o));

  a_r9_target_held: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(tgt_code_q));

  a_r2_target_enabled: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> |(src_en_o & tgt_oh_q));

  a_r4_no_early_switch: assert property (@(posedge clk) disable iff (rst)
    !$stable(mst_code_q) |-> $past(busy_q && seen_q));

  a_r3_irq_needs_ie: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ie_q));
endmodule

bind mcs_switch_ctrl mcs_checker #(.NSRC(NSRC), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .sel_o(sel_o), .src_en_o(src_en_o), .irq_o(irq_o),
  .tgt_code_q(tgt_code_q), .tgt_oh_q(tgt_oh_q), .mst_code_q(mst_code_q),
  .busy_q(busy_q), .seen_q(seen_q), .ie_q(ie_q)
);

// File: tb/sim_mcs_switch_ctrl.sv
module sim_mcs_switch_ctrl;
  localparam int PERIOD = 10;
  localparam int NV = 6;
  // {code[11:4], accepted[3], expected enables while pending[2:0]}
  localparam logic [11:0] VEC [NV] = '{
    {8'hE1, 1'b1, 3'b001}, {8'hB4, 1'b1, 3'b011}, {8'hD2, 1'b1, 3'b101},
    {8'h00, 1'b0, 3'b001}, {8'hFF, 1'b0, 3'b001}, {8'hB5, 1'b0, 3'b001}};

  logic clk = 0, rst = 1, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata_o, rd;
  logic [2:0] src_rdy_i = 0, src_en_o, sel_o;
  logic irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  mcs_switch_ctrl u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata_o(rdata_o), .src_rdy_i(src_rdy_i),
    .src_en_o(src_en_o), .sel_o(sel_o), .irq_o(irq_o));

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rdr(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst = 0; idle(1);
    // R1 reset state
    rdr(0, rd); chk("R1 target", rd, 8'hE1);
    rdr(2, rd); chk("R1 status", rd, 8'hE1);
    rdr(1, rd); chk("R1 control", rd, 8'h00);
    chk("R1 sel", {5'b0, sel_o}, 8'h01);
    chk("R1 en", {5'b0, src_en_o}, 8'h01);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);

    // R2 / R7 table: write code, check pending enables and busy, then abort
    for (int i = 0; i < NV; i++) begin
      wr(0, VEC[i][11:4]); idle(2);
      chk("R2_R7 enables", {5'b0, src_en_o}, {5'b0, VEC[i][2:0]});
      rdr(1, rd); chk("R2_R7 busy", {7'b0, rd[0]}, {7'b0, VEC[i][3]});
      wr(1, 8'h00); idle(2);
      chk("R6 enables after abort", {5'b0, src_en_o}, 8'h01);
      rdr(2, rd); chk("R6 status after abort", rd, 8'hE1);
    end

    // R3 / R4 / R8 / R5: switch to crystal with interrupts enabled
    wr(1, 8'h05);
    wr(0, 8'hB4); idle(4);
    rdr(1, rd); chk("R3 flag low before ready", rd, 8'h05);
    chk("R3 irq low before ready", {7'b0, irq_o}, 8'h00);
    wr(1, 8'h0F); idle(2);
    rdr(2, rd); chk("R4 early execute ignored", rd, 8'hE1);
    chk("R4 sel unchanged", {5'b0, sel_o}, 8'h01);
    src_rdy_i = 3'b010; idle(3);
    rdr(1, rd); chk("R3 flag set", rd, 8'h07);
    chk("R3 irq with ie", {7'b0, irq_o}, 8'h01);
    wr(1, 8'h05); idle(3);
    rdr(1, rd); chk("R8 flag cleared busy kept", rd, 8'h05);
    chk("R8 irq dropped", {7'b0, irq_o}, 8'h00);
    rdr(2, rd); chk("R4 status still old", rd, 8'hE1);
    wr(1, 8'h0D); idle(2);
    rdr(2, rd); chk("R5 status new", rd, 8'hB4);
    rdr(1, rd); chk("R5 busy cleared", rd, 8'h04);
    chk("R5 sel", {5'b0, sel_o}, 8'h02);
    chk("R5 en", {5'b0, src_en_o}, 8'h02);

    // R9 write while busy ignored; R6 abort beats execute
    wr(1, 8'h01);
    wr(0, 8'hD2);
    wr(0, 8'hE1);
    rdr(0, rd); chk("R9 target held", rd, 8'hD2);
    src_rdy_i = 3'b110; idle(3);
    rdr(1, rd); chk("R6 flag before collision", rd, 8'h03);
    wr(1, 8'h0A); idle(2);
    rdr(2, rd); chk("R6 abort wins status", rd, 8'hB4);
    rdr(1, rd); chk("R6 abort wins control", rd, 8'h00);
    chk("R6 sel", {5'b0, sel_o}, 8'h02);
    chk("R6 en", {5'b0, src_en_o}, 8'h02);

    // R3 no interrupt with ie clear; back to RC/8
    src_rdy_i = 3'b011;
    wr(0, 8'hE1); idle(4);
    rdr(1, rd); chk("R3 flag without ie", rd, 8'h03);
    chk("R3 irq stays low", {7'b0, irq_o}, 8'h00);
    wr(1, 8'h0B); idle(2);
    rdr(2, rd); chk("R5 status back", rd, 8'hE1);
    chk("R5 sel back", {5'b0, sel_o}, 8'h01);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule